// File: doc/BRIEF.md
# End-of-Write Status Reporter

This block gives a host three ways to learn when an internal programming cycle of a byte-wide nonvolatile memory has finished. A one-cycle commit pulse starts the cycle and captures the byte that was just written, with its address. From the following clock the block is busy for a fixed number of clocks, set by a parameter. During that time it drives an active-low ready/busy line, modelled as a pull-down enable: the line is pulled to 0 while busy and left undriven once the cycle ends.

While the block is busy, any read strobe returns a status byte in place of array data. Bit 7 is the polling bit. On a read of the last written address it carries the inverse of the written bit 7. Bit 6 is a toggle bit that alternates on every status read of any address. It starts at 0 for each new programming cycle. When the block is idle, a read returns the array data supplied by the surrounding memory, so the true stored value shows once the cycle has ended.

Each read response is registered. The response appears in the clock after the strobe and lasts one clock. Next to the data the block drives a per-bit output-enable mask, so bits that carry nothing during busy stay undriven.

Top module: `eow_status_reporter`

## Requirements
- R1: After reset the pull-down enable is 0, the response output-enable mask is 8'h00 and the response data is 8'h00.
- R2: A commit pulse taken while idle raises the pull-down enable from the next clock, for exactly CYC_CLKS clocks, after which it returns to 0 (released).
- R3: A commit pulse that arrives while busy is ignored. It neither restarts nor extends the busy period, and it does not replace the captured address or data.
- R4: A busy read of the last committed address returns bit 7 equal to the inverse of the committed data bit 7, with mask bit 7 set.
- R5: A busy read returns bits 5..0 as 0 with mask bits 5..0 clear. For an address other than the last committed one, bit 7 is 0 with mask bit 7 clear, so the mask is 8'h40.
- R6: Bit 6 of successive busy reads, of any address, runs 0,1,0,1... with mask bit 6 set. The first busy read after every accepted commit returns 0.
- R7: A read while idle returns the array data input unchanged, with mask 8'hFF.
- R8: The read response appears in the clock after the strobe and lasts one clock. In a clock with no strobe the next mask is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_i | input | 1 | One-clock pulse that starts a programming cycle |
| commit_addr_i | input | ADDR_W | Address of the byte being committed |
| commit_data_i | input | 8 | Data of the byte being committed |
| rd_stb_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Address of the read |
| array_data_i | input | 8 | Stored data for the read address, from the array |
| rsp_data_o | output | 8 | Read response data |
| rsp_oe_o | output | 8 | Per-bit output enable of the read response |
| rb_pull_o | output | 1 | Ready/busy pull-down enable (1 = line pulled low) |

## Verification
The bench counts the clocks during which the pull-down enable is high. A counter that is off by one, or a busy flag tied to the commit clock itself, would give CYC_CLKS plus or minus one. A second commit is sent mid-cycle to a new address. A design that restarts its timer would stay busy too long, and one that recaptures would flip the polling mask for that address. The toggle sequence is read across two cycles that end after an odd number of reads, so a toggle that is not cleared on commit would start the second cycle at 1. Idle reads and reads with committed bit 7 at both values catch a polling bit that is not inverted or that leaks into idle data.

// File: rtl/eow_pkg.sv
package eow_pkg;
  localparam int DATA_W   = 8;
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  function automatic logic eow_poll_bit(input logic [DATA_W-1:0] wr_data);
    return ~wr_data[POLL_BIT];
  endfunction

  function automatic logic [DATA_W-1:0] eow_status_word(input logic hit,
                                                        input logic poll,
                                                        input logic tog);
    logic [DATA_W-1:0] w;
    w = '0;
    w[POLL_BIT] = hit & poll;
    w[TOG_BIT]  = tog;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] eow_status_mask(input logic hit);
    logic [DATA_W-1:0] m;
    m = '0;
    m[POLL_BIT] = hit;
    m[TOG_BIT]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/eow_cycle_timer.sv
module eow_cycle_timer #(
  parameter int CYC_CLKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYC_CLKS + 1);
  localparam int RUN_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [RUN_W-1:0] run_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i && cnt_q == '0) begin
      cnt_q <= CNT_W'(CYC_CLKS);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len_q <= '0;
    else if (busy_o) run_len_q <= run_len_q + 1'b1;
    else             run_len_q <= '0;
  end

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_len_q == RUN_W'(CYC_CLKS)));

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/eow_write_capture.sv
module eow_write_capture #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic [7:0]        last_data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr_o <= '0;
      last_data_o <= '0;
    end else if (take_i) begin
      last_addr_o <= addr_i;
      last_data_o <= data_i;
    end
  end

  assert_hold_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(last_addr_o) && $stable(last_data_o)));
endmodule

// File: rtl/eow_status_former.sv
module eow_status_former #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              new_cycle_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [7:0]        last_data_i,
  output logic [7:0]        rsp_data_o,
  output logic [7:0]        rsp_oe_o
);
  import eow_pkg::*;

  logic       tog_q;
  logic       addr_hit;
  logic       status_rd;
  logic [7:0] nxt_data;
  logic [7:0] nxt_oe;

  assign addr_hit  = (rd_addr_i == last_addr_i);
  assign status_rd = rd_stb_i & busy_i;

  always_comb begin
    nxt_data = '0;
    nxt_oe   = '0;
    if (status_rd) begin
      nxt_data = eow_status_word(addr_hit, eow_poll_bit(last_data_i), tog_q);
      nxt_oe   = eow_status_mask(addr_hit);
    end else if (rd_stb_i) begin
      nxt_data = array_data_i;
      nxt_oe   = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (new_cycle_i) begin
      tog_q <= 1'b0;
    end else if (status_rd) begin
      tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data_o <= '0;
      rsp_oe_o   <= '0;
    end else begin
      rsp_data_o <= nxt_data;
      rsp_oe_o   <= nxt_oe;
    end
  end

  assert_toggle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    new_cycle_i |=> !tog_q);

  assert_poll_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && addr_hit) |=> (rsp_oe_o[7] && rsp_data_o[7] != $past(last_data_i[7])));

  assert_status_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (rsp_oe_o[5:0] == 6'd0 && rsp_oe_o[6]));

  assert_idle_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !busy_i) |=> (rsp_oe_o == 8'hFF && rsp_data_o == $past(array_data_i)));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> (rsp_oe_o == 8'h00));
endmodule

// File: rtl/eow_status_reporter.sv
module eow_status_reporter #(
  parameter int ADDR_W   = 13,
  parameter int CYC_CLKS = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] commit_addr_i,
  input  logic [7:0]        commit_data_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        rsp_data_o,
  output logic [7:0]        rsp_oe_o,
  output logic              rb_pull_o
);
  logic              busy;
  logic              cycle_done;
  logic              commit_take;
  logic [ADDR_W-1:0] last_addr;
  logic [7:0]        last_data;

  assign commit_take = commit_i & ~busy;

  eow_cycle_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (commit_take),
    .busy_o  (busy),
    .done_o  (cycle_done)
  );

  eow_write_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (commit_take),
    .busy_i      (busy),
    .addr_i      (commit_addr_i),
    .data_i      (commit_data_i),
    .last_addr_o (last_addr),
    .last_data_o (last_data)
  );

  eow_status_former #(.ADDR_W(ADDR_W)) u_former (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy),
    .new_cycle_i  (commit_take),
    .rd_stb_i     (rd_stb_i),
    .rd_addr_i    (rd_addr_i),
    .array_data_i (array_data_i),
    .last_addr_i  (last_addr),
    .last_data_i  (last_data),
    .rsp_data_o   (rsp_data_o),
    .rsp_oe_o     (rsp_oe_o)
  );

  assign rb_pull_o = busy;

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !rb_pull_o);
endmodule

// File: tb/eow_status_reporter_tb.sv
module eow_status_reporter_tb;
  localparam int AW  = 13;
  localparam int CYC = 40;
  localparam int VW  = AW + 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          commit_i = 1'b0;
  logic [AW-1:0] commit_addr_i = '0;
  logic [7:0]    commit_data_i = '0;
  logic          rd_stb_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    array_data_i = '0;
  logic [7:0]    rsp_data_o;
  logic [7:0]    rsp_oe_o;
  logic          rb_pull_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  eow_status_reporter #(.ADDR_W(AW), .CYC_CLKS(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .commit_addr_i(commit_addr_i),
    .commit_data_i(commit_data_i), .rd_stb_i(rd_stb_i), .rd_addr_i(rd_addr_i),
    .array_data_i(array_data_i), .rsp_data_o(rsp_data_o), .rsp_oe_o(rsp_oe_o),
    .rb_pull_o(rb_pull_o)
  );

  // {read address, array data, expected data, expected mask}, after commit of 8'h3C at 13'h0A5
  localparam logic [VW-1:0] VEC [6] = '{
    {13'h0A5, 8'h5A, 8'h80, 8'hC0},
    {13'h100, 8'h5A, 8'h40, 8'h40},
    {13'h0A5, 8'hFF, 8'h80, 8'hC0},
    {13'h0A5, 8'h00, 8'hC0, 8'hC0},
    {13'h1FF, 8'h5A, 8'h00, 8'h40},
    {13'h0A4, 8'h5A, 8'h40, 8'h40}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic commit(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    commit_i = 1'b1; commit_addr_i = a; commit_data_i = d;
    @(negedge clk);
    commit_i = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] arr);
    @(negedge clk);
    rd_stb_i = 1'b1; rd_addr_i = a; array_data_i = arr;
    @(negedge clk);
    rd_stb_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * CYC && rb_pull_o; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pull", 32'(rb_pull_o), 0);
    check("R1 mask", 32'(rsp_oe_o), 0);
    check("R1 data", 32'(rsp_data_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 idle read
    do_read(13'h0A5, 8'hA7);
    check("R7 data", 32'(rsp_data_o), 32'hA7);
    check("R7 mask", 32'(rsp_oe_o), 32'hFF);
    @(negedge clk);
    check("R8 one clock", 32'(rsp_oe_o), 0);

    // table walk, R4 R5 R6
    check("R2 idle before", 32'(rb_pull_o), 0);
    commit(13'h0A5, 8'h3C);
    check("R2 busy next clock", 32'(rb_pull_o), 1);
    for (int i = 0; i < 6; i++) begin
      do_read(VEC[i][VW-1:24], VEC[i][23:16]);
      check("R4 R5 R6 data", 32'(rsp_data_o), 32'(VEC[i][15:8]));
      check("R4 R5 R6 mask", 32'(rsp_oe_o), 32'(VEC[i][7:0]));
    end
    wait_idle();
    do_read(13'h0A5, 8'h3C);
    check("R7 true value", 32'(rsp_data_o), 32'h3C);
    check("R7 mask after", 32'(rsp_oe_o), 32'hFF);

    // R2 exact length
    commit(13'h010, 8'h9E);
    n = 0;
    for (int i = 0; i < 4 * CYC && rb_pull_o; i++) begin n++; @(negedge clk); end
    check("R2 length", 32'(n), 32'(CYC));

    // R3 commit while busy, then R4 with bit7=1 -> poll 0
    commit(13'h010, 8'h9E);
    n = 0;
    for (int i = 0; i < 4 * CYC && rb_pull_o; i++) begin
      commit_i = (i == 10);
      commit_addr_i = 13'h055; commit_data_i = 8'h7F;
      n += (i >= 10) ? 0 : 0;
      n++;
      @(negedge clk);
      commit_i = 1'b0;
      if (i == 12) begin
        rd_stb_i = 1'b1; rd_addr_i = 13'h055;
      end else if (i == 13) begin
        rd_stb_i = 1'b0;
        check("R3 addr kept mask", 32'(rsp_oe_o), 32'h40);
        rd_stb_i = 1'b1; rd_addr_i = 13'h010;
      end else if (i == 14) begin
        rd_stb_i = 1'b0;
        check("R4 poll of 1", 32'(rsp_data_o), 32'h40);
        check("R4 poll mask", 32'(rsp_oe_o), 32'hC0);
        n++;
        i++;
        if (!rb_pull_o) break;
        @(negedge clk);
      end
    end
    rd_stb_i = 1'b0;
    check("R3 length unchanged", 32'(n), 32'(CYC));

    // R6 toggle restarts at 0 after odd number of reads
    commit(13'h020, 8'h00);
    do_read(13'h020, 8'h00);
    check("R6 first", 32'(rsp_data_o[6]), 0);
    wait_idle();
    commit(13'h020, 8'h00);
    do_read(13'h021, 8'h00);
    check("R6 restart", 32'(rsp_data_o[6]), 0);
    do_read(13'h021, 8'h00);
    check("R6 second", 32'(rsp_data_o[6]), 1);
    wait_idle();
    check("R2 released", 32'(rb_pull_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule